// File: doc/BRIEF.md
# Unaligned Burst Read Aligner

This block sits between a word-oriented read master and a cache port that only hands out whole, naturally aligned lines. The master presents a word-aligned address and a burst length of one to four 32-bit words. The block finds the aligned line or lines that hold those words and fetches them one after another. It keeps the returned lines in a two-line buffer, picks out the requested words and streams them back one word per cycle.

The downstream side stores bytes big-endian within a line, and the master expects little-endian words. The block therefore reverses byte order on every word it returns. A burst that runs past the end of one line needs the following line as well, and the bytes it does not use are dropped. The line size is a parameter. The 16-byte setting serves data reads, and the 32-byte setting serves instruction fills through the same logic.

Top module: `burst_read_aligner`

## Requirements
- R1: After reset, `up_waitrequest`, `up_readdatavalid` and `dn_req_valid` are all low.
- R2: A read is accepted on a clock edge where `up_read` is high and `up_waitrequest` is low. From the next cycle `up_waitrequest` stays high until the last beat has been delivered. A read driven while `up_waitrequest` is high causes no line fetch and no beat.
- R3: While `dn_req_valid` is high and `dn_req_ready` is low, the request stays valid and `dn_req_addr` does not change.
- R4: Every line request address has its low log2(LINE_BYTES) bits at zero. Let the offset be the address modulo LINE_BYTES. When offset + 4*burstcount <= LINE_BYTES, exactly one request is made, for the line that holds the address.
- R5: When offset + 4*burstcount > LINE_BYTES, exactly two requests are made: first the line that holds the address, then the line at that address plus LINE_BYTES. The second request is raised only after the first line's response has been taken.
- R6: `up_readdatavalid` is high for exactly burstcount consecutive cycles. Beat k carries the word at request address + 4*k.
- R7: In a returned line, the byte at line offset j sits in bits [8*LINE_BYTES-1-8*j -: 8]. The word returned for byte address a is {byte(a+3), byte(a+2), byte(a+1), byte(a)}, with byte(a) in bits [7:0].
- R8: `up_readdatavalid` is never high in a cycle where a line request is pending or a line response is still awaited.
- R9: With LINE_BYTES = 32, R4 to R7 hold with 32-byte lines. A 4-word burst at offset 0x1C fetches two lines, and one at offset 0x04 fetches one.
- R10: `up_waitrequest` is low in the cycle right after the last beat, so a new read can be accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_read | input | 1 | Master read request |
| up_address | input | ADDR_W | Word-aligned byte address of the first word |
| up_burstcount | input | BC_W | Number of words, 1 to MAX_BURST |
| up_waitrequest | output | 1 | High while a burst is in progress |
| up_readdata | output | 32 | Returned word, little-endian |
| up_readdatavalid | output | 1 | Marks a valid returned word |
| dn_req_valid | output | 1 | Line fetch request |
| dn_req_ready | input | 1 | Fetch request accepted |
| dn_req_addr | output | ADDR_W | Line-aligned fetch address |
| dn_rsp_valid | input | 1 | Line data valid |
| dn_rsp_data | input | 8*LINE_BYTES | Line data, big-endian by byte |

## Verification
The hardest case to reach from the ports is the straddling burst. Here the second line request has to wait for the first line's data, and the output words come from the tail of one line and the head of the next. The directed tests use addresses whose offsets sit a few bytes below a line boundary, including the 4-word burst at 0x000FFFFC and a 2-word burst at offset 0xC. The line model answers with a delay and counts any request raised while it still owes a response. It also logs the addresses fetched, so the two-fetch order and the stitched bytes are both checked.

// File: rtl/brra_pkg.sv
package brra_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_A,
        ST_WAIT_A,
        ST_FETCH_B,
        ST_WAIT_B,
        ST_STREAM
    } brra_state_e;

endpackage

// File: rtl/brra_span_calc.sv
module brra_span_calc #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int BC_W       = 3,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int SUM_W     = OFF_W + 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BC_W-1:0]   burst_i,
    output logic [ADDR_W-1:0] first_line_o,
    output logic [OFF_W-1:0]  offset_o,
    output logic              straddle_o
);

    logic [SUM_W-1:0] end_byte;

    always_comb begin
        offset_o     = addr_i[OFF_W-1:0];
        first_line_o = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        end_byte     = SUM_W'(addr_i[OFF_W-1:0]) + SUM_W'({burst_i, 2'b00});
        straddle_o   = end_byte > SUM_W'(LINE_BYTES);
    end

endmodule

// File: rtl/brra_word_pick.sv
module brra_word_pick #(
    parameter int LINE_BYTES = 16,
    localparam int PAIR_BITS = 16 * LINE_BYTES,
    localparam int IDX_W     = $clog2(LINE_BYTES) + 1
) (
    input  logic [PAIR_BITS-1:0] pair_i,
    input  logic [IDX_W-1:0]     byte_idx_i,
    output logic [31:0]          word_o
);

    always_comb begin
        word_o = '0;
        for (int i = 0; i < 4; i++) begin
            word_o[8*i +: 8] = pair_i[PAIR_BITS-1-8*(int'(byte_idx_i)+i) -: 8];
        end
    end

endmodule

// File: rtl/burst_read_aligner.sv
module burst_read_aligner #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int MAX_BURST  = 4,
    localparam int BC_W      = $clog2(MAX_BURST) + 1,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = OFF_W + 1,
    localparam int LINE_BITS = 8 * LINE_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 up_read,
    input  logic [ADDR_W-1:0]    up_address,
    input  logic [BC_W-1:0]      up_burstcount,
    output logic                 up_waitrequest,
    output logic [31:0]          up_readdata,
    output logic                 up_readdatavalid,
    output logic                 dn_req_valid,
    input  logic                 dn_req_ready,
    output logic [ADDR_W-1:0]    dn_req_addr,
    input  logic                 dn_rsp_valid,
    input  logic [LINE_BITS-1:0] dn_rsp_data
);
    import brra_pkg::*;

    typedef struct packed {
        brra_state_e            state;
        logic [ADDR_W-1:0]      line;
        logic                   two;
        logic [OFF_W-1:0]       off;
        logic [BC_W-1:0]        bc;
        logic [BC_W-1:0]        cnt;
        logic [2*LINE_BITS-1:0] pair;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0] span_line;
    logic [OFF_W-1:0]  span_off;
    logic              span_two;
    logic [IDX_W-1:0]  pick_idx;
    logic [31:0]       pick_word;

    brra_span_calc #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .BC_W(BC_W)
    ) u_span (
        .addr_i       (up_address),
        .burst_i      (up_burstcount),
        .first_line_o (span_line),
        .offset_o     (span_off),
        .straddle_o   (span_two)
    );

    assign pick_idx = IDX_W'(r_q.off) + IDX_W'({r_q.cnt, 2'b00});

    brra_word_pick #(
        .LINE_BYTES(LINE_BYTES)
    ) u_pick (
        .pair_i     (r_q.pair),
        .byte_idx_i (pick_idx),
        .word_o     (pick_word)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (up_read) begin
                    r_d.line  = span_line;
                    r_d.off   = span_off;
                    r_d.two   = span_two;
                    r_d.bc    = up_burstcount;
                    r_d.cnt   = '0;
                    r_d.state = ST_FETCH_A;
                end
            end
            ST_FETCH_A: if (dn_req_ready) r_d.state = ST_WAIT_A;
            ST_WAIT_A: begin
                if (dn_rsp_valid) begin
                    r_d.pair[2*LINE_BITS-1 -: LINE_BITS] = dn_rsp_data;
                    r_d.state = r_q.two ? ST_FETCH_B : ST_STREAM;
                end
            end
            ST_FETCH_B: if (dn_req_ready) r_d.state = ST_WAIT_B;
            ST_WAIT_B: begin
                if (dn_rsp_valid) begin
                    r_d.pair[LINE_BITS-1:0] = dn_rsp_data;
                    r_d.state = ST_STREAM;
                end
            end
            ST_STREAM: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == r_q.bc - 1'b1) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign up_waitrequest   = (r_q.state != ST_IDLE);
    assign up_readdatavalid = (r_q.state == ST_STREAM);
    assign up_readdata      = pick_word;
    assign dn_req_valid     = (r_q.state == ST_FETCH_A) || (r_q.state == ST_FETCH_B);
    assign dn_req_addr      = (r_q.state == ST_FETCH_B) ? r_q.line + ADDR_W'(LINE_BYTES) : r_q.line;

    // R3: a stalled line request holds its address
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_addr));

    // R4: fetch addresses are line aligned
    a_r4_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> dn_req_addr[OFF_W-1:0] == '0);

    // R8: no beat while a fetch is pending
    a_r8_no_beat_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> !up_readdatavalid);

    // R2: an accepted read makes the port busy next cycle
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        up_read && !up_waitrequest |=> up_waitrequest);

    // R6: beat index stays inside the burst
    a_r6_beat_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        up_readdatavalid |-> r_q.cnt < r_q.bc);

endmodule

// File: tb/burst_read_aligner_tb.sv
module brra_line_model #(
    parameter int LINE_BYTES = 16,
    parameter int LAT        = 3
) (
    input  logic                    clk,
    input  logic                    req_valid,
    input  logic [31:0]             req_addr,
    output logic                    req_ready,
    output logic                    rsp_valid,
    output logic [8*LINE_BYTES-1:0] rsp_data,
    output int                      fetch_cnt,
    output int                      early_cnt,
    output logic [31:0]             prev_addr,
    output logic [31:0]             last_addr
);
    function automatic logic [7:0] mb(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ {a[3:0], a[7:4]} ^ 8'hA5;
    endfunction

    initial begin
        req_ready = 0; rsp_valid = 0; rsp_data = '0;
        fetch_cnt = 0; early_cnt = 0; prev_addr = '0; last_addr = '0;
        forever begin
            @(negedge clk);
            if (req_valid && !req_ready) begin
                req_ready = 1;
                prev_addr = last_addr;
                last_addr = req_addr;
                fetch_cnt++;
                @(negedge clk);
                req_ready = 0;
                repeat (LAT) begin
                    @(negedge clk);
                    if (req_valid) early_cnt++;
                end
                for (int j = 0; j < LINE_BYTES; j++)
                    rsp_data[8*LINE_BYTES-1-8*j -: 8] = mb(last_addr + j);
                rsp_valid = 1;
                @(negedge clk);
                rsp_valid = 0;
            end
        end
    end
endmodule

module burst_read_aligner_tb;
    logic clk = 0;
    logic rst_n = 0;
    always #4 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // 16-byte line instance
    logic        a_read = 0;
    logic [31:0] a_addr = '0;
    logic [2:0]  a_bc = '0;
    logic        a_wait, a_rdv, a_rqv, a_rqr, a_rsv;
    logic [31:0] a_rdata, a_rqa;
    logic [127:0] a_rsd;
    int a_fc, a_ec;
    logic [31:0] a_pa, a_la;

    // 32-byte line instance
    logic        b_read = 0;
    logic [31:0] b_addr = '0;
    logic [2:0]  b_bc = '0;
    logic        b_wait, b_rdv, b_rqv, b_rqr, b_rsv;
    logic [31:0] b_rdata, b_rqa;
    logic [255:0] b_rsd;
    int b_fc, b_ec;
    logic [31:0] b_pa, b_la;

    burst_read_aligner #(.LINE_BYTES(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .up_read(a_read), .up_address(a_addr),
        .up_burstcount(a_bc), .up_waitrequest(a_wait), .up_readdata(a_rdata),
        .up_readdatavalid(a_rdv), .dn_req_valid(a_rqv), .dn_req_ready(a_rqr),
        .dn_req_addr(a_rqa), .dn_rsp_valid(a_rsv), .dn_rsp_data(a_rsd));

    brra_line_model #(.LINE_BYTES(16), .LAT(3)) u_mem_a (
        .clk(clk), .req_valid(a_rqv), .req_addr(a_rqa), .req_ready(a_rqr),
        .rsp_valid(a_rsv), .rsp_data(a_rsd), .fetch_cnt(a_fc), .early_cnt(a_ec),
        .prev_addr(a_pa), .last_addr(a_la));

    burst_read_aligner #(.LINE_BYTES(32)) u_dut32 (
        .clk(clk), .rst_n(rst_n), .up_read(b_read), .up_address(b_addr),
        .up_burstcount(b_bc), .up_waitrequest(b_wait), .up_readdata(b_rdata),
        .up_readdatavalid(b_rdv), .dn_req_valid(b_rqv), .dn_req_ready(b_rqr),
        .dn_req_addr(b_rqa), .dn_rsp_valid(b_rsv), .dn_rsp_data(b_rsd));

    brra_line_model #(.LINE_BYTES(32), .LAT(2)) u_mem_b (
        .clk(clk), .req_valid(b_rqv), .req_addr(b_rqa), .req_ready(b_rqr),
        .rsp_valid(b_rsv), .rsp_data(b_rsd), .fetch_cnt(b_fc), .early_cnt(b_ec),
        .prev_addr(b_pa), .last_addr(b_la));

    function automatic logic [7:0] mb(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ {a[3:0], a[7:4]} ^ 8'hA5;
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        return {mb(a + 3), mb(a + 2), mb(a + 1), mb(a)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // One burst on either instance; poke drives a read while busy (R2).
    task automatic do_read(input bit fill, input logic [31:0] addr, input int bc,
                           input int exp_fetch, input bit poke, input string req);
        int fc0, ec0, guard, lb, fc, ec;
        logic [31:0] la, pa, first;
        fc0 = fill ? b_fc : a_fc;
        ec0 = fill ? b_ec : a_ec;
        lb  = fill ? 32 : 16;
        @(negedge clk);
        if (fill) begin b_read = 1; b_addr = addr; b_bc = 3'(bc); end
        else      begin a_read = 1; a_addr = addr; a_bc = 3'(bc); end
        @(negedge clk);
        b_read = 0; a_read = 0;
        chk((fill ? b_wait : a_wait) == 1'b1, "R2 busy after accept", 32'(fill ? b_wait : a_wait), 1);
        if (poke) begin
            a_read = 1; a_addr = 32'h0000_ABC0; a_bc = 3'd4;
            @(negedge clk);
            a_read = 0;
        end
        guard = 0;
        while (!(fill ? b_rdv : a_rdv) && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        for (int k = 0; k < bc; k++) begin
            logic v;
            logic [31:0] d;
            v = fill ? b_rdv : a_rdv;
            d = fill ? b_rdata : a_rdata;
            chk(v == 1'b1, "R6 beat valid", 32'(v), 1);
            chk(d == exp_word(addr + 4*k), $sformatf("%s R7 word %0d", req, k), d, exp_word(addr + 4*k));
            @(negedge clk);
        end
        chk((fill ? b_rdv : a_rdv) == 1'b0, "R6 exact beat count", 32'(fill ? b_rdv : a_rdv), 0);
        chk((fill ? b_wait : a_wait) == 1'b0, "R10 ready after last beat", 32'(fill ? b_wait : a_wait), 0);
        fc = (fill ? b_fc : a_fc) - fc0;
        ec = (fill ? b_ec : a_ec) - ec0;
        la = fill ? b_la : a_la;
        pa = fill ? b_pa : a_pa;
        first = addr & ~32'(lb - 1);
        chk(fc == exp_fetch, $sformatf("%s fetch count", req), 32'(fc), 32'(exp_fetch));
        chk(ec == 0, "R5 second fetch after first response", 32'(ec), 0);
        if (exp_fetch == 1)
            chk(la == first, $sformatf("%s line address", req), la, first);
        else begin
            chk(pa == first, $sformatf("%s first line", req), pa, first);
            chk(la == first + 32'(lb), $sformatf("%s second line", req), la, first + 32'(lb));
        end
    endtask

    task automatic t_reset();
        chk(a_wait == 0, "R1 waitrequest after reset", 32'(a_wait), 0);
        chk(a_rdv == 0, "R1 readdatavalid after reset", 32'(a_rdv), 0);
        chk(a_rqv == 0, "R1 req_valid after reset", 32'(a_rqv), 0);
        chk(b_wait == 0, "R1 fill waitrequest after reset", 32'(b_wait), 0);
    endtask

    task automatic t_aligned();
        do_read(0, 32'h0000_0100, 4, 1, 0, "R4 full line");
        do_read(0, 32'h0000_0204, 2, 1, 0, "R4 inner pair");
        do_read(0, 32'h0000_040C, 1, 1, 0, "R4 last word of line");
        do_read(0, 32'h0000_0508, 2, 1, 0, "R4 ends on boundary");
    endtask

    task automatic t_straddle();
        do_read(0, 32'h000F_FFFC, 4, 2, 0, "R5 four words across line");
        do_read(0, 32'h0000_030C, 2, 2, 0, "R5 two words at 0xC");
        do_read(0, 32'h0000_0738, 3, 2, 0, "R5 three words across line");
    endtask

    task automatic t_busy();
        do_read(0, 32'h0000_0820, 4, 1, 1, "R2 read ignored while busy");
        do_read(0, 32'h0000_0904, 1, 1, 0, "R10 back to back");
    endtask

    task automatic t_fill();
        do_read(1, 32'h0000_001C, 4, 2, 0, "R9 fill straddle");
        do_read(1, 32'h0000_0024, 4, 1, 0, "R9 fill single line");
        do_read(1, 32'h0001_FFF8, 4, 2, 0, "R9 fill wrap");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset();
        t_aligned();
        t_straddle();
        t_busy();
        t_fill();
        done = 1;
        finish_run();
    end
endmodule